// File: doc/BRIEF.md
# Management-Bus Target with Alert Response

This block is a passive target for a shared two-wire management bus of the SMBus/PMBus kind. It samples the open-drain clock and data lines through synchronizers and finds START and STOP conditions. It takes in the first byte of each transaction and acknowledges it when the byte names the configured 7-bit device address. Any further command traffic after that acknowledge belongs to other logic. The target never drives the clock line. Its timing depends only on the edges it sees, so any other device on the bus may stretch the clock.

Local logic raises an alert request, and the target then pulls its open-drain ALERT line low. The host asks who is alerting by reading from the Alert Response Address. Every alerting target acknowledges that read and then sends its own address. Wired-AND arbitration on the data line settles the reply, and the lowest address comes through intact. A target that sent its address cleanly drops ALERT. A target that lost stays quiet and keeps ALERT asserted, so the host can poll again. If the clock stays low for too long, the target abandons the transfer and reports a timeout.

Top module: `smbus_alert_target`

## Requirements
- R1: A START is a falling data line while the clock line is high. After reset the target acknowledges nothing until it has seen a START.
- R2: The first byte after a START is taken MSB first on rising clock edges. Bits 7:1 are the address and bit 0 is the read/write bit. When bits 7:1 equal `own_addr`, the target pulls data low through the ninth clock, for either direction.
- R3: When the address does not match, the target drives nothing until the next START, even if later bits spell its own address.
- R4: While an alert is pending, the byte `{7'b0001100, 1'b1}` is acknowledged. The target then sends `{own_addr, 1'b0}` MSB first, changing data only after falling clock edges.
- R5: At each rising clock edge of the reply where the target sends a 1, it samples data. If data reads 0, the target has lost: it releases data for the rest of the transfer and keeps ALERT asserted.
- R6: A rising edge on `alert_req` makes an alert pending, and `alert_pull` is high while one is pending. The alert clears only at the falling clock edge after the eighth reply bit has been sent without a loss.
- R7: A read of the Alert Response Address with no alert pending is not acknowledged. A write to that address is never acknowledged, and the pending alert is kept.
- R8: The target has no clock output. It accepts low periods of any length below the timeout limit without error.
- R9: After `LOW_LIMIT` consecutive system clocks with the clock line low, `bus_timeout` pulses for one cycle. Data is released, the target returns to idle, and a pending alert is kept.
- R10: A STOP (data rising while the clock is high) returns the target to idle with data released. A START in any state restarts address reception.
- R11: During and just after reset, `sda_pull`, `alert_pull` and `bus_timeout` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level (asynchronous) |
| sda_in | input | 1 | Bus data line level (asynchronous) |
| own_addr | input | 7 | Device address of this target |
| alert_req | input | 1 | Alert request from local logic, acting on its rising edge |
| sda_pull | output | 1 | 1 pulls the data line low |
| alert_pull | output | 1 | 1 pulls the shared ALERT line low |
| bus_timeout | output | 1 | One-cycle pulse when the clock-low limit expires |

## Verification
The hardest situation to reach is arbitration loss in the middle of the alert reply. It needs a second alerting device with a lower address driving the same data line, bit by bit, in step with the target. The bench builds the wired-AND of host, target and a modelled competitor, and drops the competitor when that device loses. Pairs of addresses that first differ at a late bit exercise both winning and losing. The timeout is reached by stopping the clock low while the target itself holds data low, which shows that expiry releases a line that is actively driven.

// File: rtl/smbt_pkg.sv
package smbt_pkg;

  localparam logic [6:0] ALERT_RESP_ADDR = 7'b0001100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACKW,
    ST_ACK,
    ST_REPLY,
    ST_DONE,
    ST_HOLD
  } st_e;

  // Bit idx of the alert reply byte {addr, 0}.
  function automatic logic reply_bit(input logic [6:0] addr, input logic [2:0] idx);
    logic [7:0] rb;
    rb = {addr, 1'b0};
    return rb[idx];
  endfunction

  // Received byte is an alert-response read and an alert is pending.
  function automatic logic ara_hit(input logic [7:0] rx, input logic pend);
    return (rx == {ALERT_RESP_ADDR, 1'b1}) && pend;
  endfunction

  function automatic logic own_hit(input logic [7:0] rx, input logic [6:0] addr);
    return rx[7:1] == addr;
  endfunction

endpackage

// File: rtl/smbt_line_sync.sv
module smbt_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] ff;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff   <= '1;
      prev <= 1'b1;
    end else begin
      ff   <= {ff[STAGES-2:0], raw};
      prev <= ff[STAGES-1];
    end
  end

  assign lvl  = ff[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/smbt_low_guard.sv
module smbt_low_guard #(
  parameter int LIMIT = 2_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_lvl,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (scl_lvl)           cnt <= '0;
    else if (cnt != CW'(LIMIT)) cnt <= cnt + 1'b1;
  end

  assign expire = !scl_lvl && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/smbus_alert_target.sv
module smbus_alert_target
  import smbt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOW_LIMIT   = 2_500_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [6:0] own_addr,
  input  logic       alert_req,
  output logic       sda_pull,
  output logic       alert_pull,
  output logic       bus_timeout
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_v, lvl_v, rise_v, fall_v;
  assign raw_v = {sda_in, scl_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    smbt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst_n(rst_n),
      .raw (raw_v[g]),
      .lvl (lvl_v[g]),
      .rise(rise_v[g]),
      .fall(fall_v[g])
    );
  end

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, sda_rise, sda_fall;
  assign scl_lvl  = lvl_v[0];
  assign sda_lvl  = lvl_v[1];
  assign scl_rise = rise_v[0];
  assign scl_fall = fall_v[0];
  assign sda_rise = rise_v[1];
  assign sda_fall = fall_v[1];

  logic tmo_evt;
  smbt_low_guard #(.LIMIT(LOW_LIMIT)) u_guard (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_lvl(scl_lvl),
    .expire (tmo_evt)
  );

  st_e        state;
  logic [2:0] bit_cnt;
  logic [2:0] bit_idx;
  logic [6:0] shreg;
  logic       ara_q;
  logic       req_q;
  logic       alert_pend;

  // Named events for the checker.
  logic       start_evt, stop_evt, lost_evt, won_evt, alert_clr_evt;
  logic [7:0] rx_byte;

  assign start_evt     = sda_fall & scl_lvl;
  assign stop_evt      = sda_rise & scl_lvl;
  assign rx_byte       = {shreg, sda_lvl};
  assign lost_evt      = (state == ST_REPLY) & scl_rise &
                         reply_bit(own_addr, bit_idx) & ~sda_lvl;
  assign won_evt       = (state == ST_REPLY) & scl_rise & ~lost_evt &
                         (bit_idx == 3'd0);
  assign alert_clr_evt = (state == ST_DONE) & scl_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sda_pull <= 1'b0;
      bit_cnt  <= '0;
      bit_idx  <= '0;
      shreg    <= '0;
      ara_q    <= 1'b0;
    end else if (tmo_evt) begin
      state    <= ST_IDLE;
      sda_pull <= 1'b0;
    end else if (start_evt) begin
      state    <= ST_ADDR;
      sda_pull <= 1'b0;
      bit_cnt  <= '0;
    end else if (stop_evt) begin
      state    <= ST_IDLE;
      sda_pull <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: if (scl_rise) begin
          shreg   <= {shreg[5:0], sda_lvl};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            if (own_hit(rx_byte, own_addr) || ara_hit(rx_byte, alert_pend)) begin
              state <= ST_ACKW;
              ara_q <= ara_hit(rx_byte, alert_pend);
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ACKW: if (scl_fall) begin
          state    <= ST_ACK;
          sda_pull <= 1'b1;
        end
        ST_ACK: if (scl_fall) begin
          if (ara_q) begin
            state    <= ST_REPLY;
            bit_idx  <= 3'd7;
            sda_pull <= ~reply_bit(own_addr, 3'd7);
          end else begin
            state    <= ST_HOLD;
            sda_pull <= 1'b0;
          end
        end
        ST_REPLY: begin
          if (lost_evt) begin
            state    <= ST_IDLE;
            sda_pull <= 1'b0;
          end else if (won_evt) begin
            state <= ST_DONE;
          end else if (scl_fall) begin
            bit_idx  <= bit_idx - 3'd1;
            sda_pull <= ~reply_bit(own_addr, bit_idx - 3'd1);
          end
        end
        ST_DONE: if (scl_fall) begin
          state    <= ST_HOLD;
          sda_pull <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q       <= 1'b0;
      alert_pend  <= 1'b0;
      bus_timeout <= 1'b0;
    end else begin
      req_q       <= alert_req;
      bus_timeout <= tmo_evt;
      if (alert_clr_evt)           alert_pend <= 1'b0;
      else if (alert_req & ~req_q) alert_pend <= 1'b1;
    end
  end

  assign alert_pull = alert_pend;

endmodule

// File: rtl/smbus_alert_target_chk.sv
module smbus_alert_target_chk
  import smbt_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input st_e  state,
  input logic sda_pull,
  input logic alert_pull,
  input logic bus_timeout,
  input logic start_evt,
  input logic stop_evt,
  input logic scl_fall,
  input logic lost_evt,
  input logic tmo_evt
);

  a_r10_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state == ST_ADDR));

  a_r10_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_pull);

  a_r5_lost_release: assert property (@(posedge clk) disable iff (!rst_n)
    lost_evt |=> (!sda_pull && alert_pull));

  a_r6_alert_clear_after_win: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alert_pull) |-> ($past(state) == ST_DONE));

  a_r9_timeout_release: assert property (@(posedge clk) disable iff (!rst_n)
    bus_timeout |-> !sda_pull);

  a_r4_drive_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> $past(scl_fall || start_evt || stop_evt || lost_evt || tmo_evt));

  a_r3_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_pull);

endmodule

bind smbus_alert_target smbus_alert_target_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .state      (state),
  .sda_pull   (sda_pull),
  .alert_pull (alert_pull),
  .bus_timeout(bus_timeout),
  .start_evt  (start_evt),
  .stop_evt   (stop_evt),
  .scl_fall   (scl_fall),
  .lost_evt   (lost_evt),
  .tmo_evt    (tmo_evt)
);

// File: tb/sim_smbus_alert_target.sv
module sim_smbus_alert_target;
  localparam int CLK_P = 10;
  localparam int HALF  = 20;
  localparam int LIM   = 300;

  typedef struct packed {
    logic [6:0] own;
    logic       req;
    logic       comp_en;
    logic [6:0] comp;
    logic [7:0] addr;
    logic       ack;
    logic       rd_en;
    logic [7:0] rd;
    logic       alert;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{7'h12, 1'b0, 1'b0, 7'h00, 8'h24, 1'b1, 1'b0, 8'h00, 1'b0},
    '{7'h12, 1'b0, 1'b0, 7'h00, 8'h26, 1'b0, 1'b0, 8'h00, 1'b0},
    '{7'h12, 1'b1, 1'b0, 7'h00, 8'h19, 1'b1, 1'b1, 8'h24, 1'b0},
    '{7'h12, 1'b1, 1'b1, 7'h13, 8'h19, 1'b1, 1'b1, 8'h24, 1'b0},
    '{7'h13, 1'b1, 1'b1, 7'h12, 8'h19, 1'b1, 1'b1, 8'h24, 1'b1},
    '{7'h13, 1'b0, 1'b0, 7'h00, 8'h19, 1'b1, 1'b1, 8'h26, 1'b0},
    '{7'h55, 1'b0, 1'b0, 7'h00, 8'h19, 1'b0, 1'b0, 8'h00, 1'b0},
    '{7'h55, 1'b1, 1'b0, 7'h00, 8'h18, 1'b0, 1'b0, 8'h00, 1'b1},
    '{7'h55, 1'b0, 1'b0, 7'h00, 8'h19, 1'b1, 1'b1, 8'hAA, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_scl = 1'b1;
  logic       host_sda = 1'b1;
  logic       comp_pull = 1'b0;
  logic       alert_req = 1'b0;
  logic [6:0] own = 7'h12;
  logic       sda_pull, alert_pull, bus_timeout;
  logic       sda_bus;

  int checks = 0;
  int fails  = 0;
  int to_cnt = 0;
  bit done   = 1'b0;

  assign sda_bus = host_sda & ~sda_pull & ~comp_pull;

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) if (bus_timeout) to_cnt++;

  smbus_alert_target #(.SYNC_STAGES(2), .LOW_LIMIT(LIM)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_in     (host_scl),
    .sda_in     (sda_bus),
    .own_addr   (own),
    .alert_req  (alert_req),
    .sda_pull   (sda_pull),
    .alert_pull (alert_pull),
    .bus_timeout(bus_timeout)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic bus_start();
    host_sda = 1'b1; wait_clk(HALF);
    host_scl = 1'b1; wait_clk(HALF);
    host_sda = 1'b0; wait_clk(HALF);
    host_scl = 1'b0;
  endtask

  task automatic bus_stop();
    wait_clk(2);
    host_sda = 1'b0; wait_clk(HALF);
    host_scl = 1'b1; wait_clk(HALF);
    host_sda = 1'b1; wait_clk(HALF);
  endtask

  task automatic clk_bit(input logic b, input int extra, output logic r);
    wait_clk(2);
    host_sda = b;
    wait_clk(HALF + extra);
    host_scl = 1'b1;
    wait_clk(HALF/2);
    r = sda_bus;
    wait_clk(HALF/2);
    host_scl = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] v, input int extra, input logic comp_ack,
                            output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], extra, r);
    wait_clk(2);
    comp_pull = comp_ack;
    clk_bit(1'b1, extra, r);
    wait_clk(2);
    comp_pull = 1'b0;
    ack = !r;
  endtask

  task automatic read_byte(input logic comp_en, input logic [7:0] cb, output logic [7:0] v);
    logic on;
    logic r;
    on = comp_en;
    for (int i = 7; i >= 0; i--) begin
      wait_clk(2);
      comp_pull = on & ~cb[i];
      clk_bit(1'b1, 0, r);
      v[i] = r;
      if (on && cb[i] && !r) on = 1'b0;
    end
    wait_clk(2);
    comp_pull = 1'b0;
    clk_bit(1'b1, 0, r);
  endtask

  task automatic pulse_alert();
    alert_req = 1'b1; wait_clk(3);
    alert_req = 1'b0; wait_clk(3);
  endtask

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic       ack;
    logic       r;
    logic [7:0] rd;

    // R11 reset state
    wait_clk(5);
    chk("R11 sda_pull in reset", sda_pull, 0);
    chk("R11 alert_pull in reset", alert_pull, 0);
    rst_n = 1'b1;
    wait_clk(5);
    chk("R11 bus_timeout after reset", bus_timeout, 0);
    chk("R11 alert_pull after reset", alert_pull, 0);

    // R1: own address clocked without a START is not acknowledged
    host_scl = 1'b0;
    write_byte(8'h24, 0, 1'b0, ack);
    chk("R1 no ack before START", ack, 0);
    host_sda = 1'b1; wait_clk(HALF);
    host_scl = 1'b1; wait_clk(HALF);

    // Table walk: R2 R3 R4 R5 R6 R7
    for (int k = 0; k < NV; k++) begin
      own = VECS[k].own;
      if (VECS[k].req) pulse_alert();
      bus_start();
      write_byte(VECS[k].addr, 0, VECS[k].comp_en && (VECS[k].addr == 8'h19), ack);
      chk($sformatf("R2 R3 R4 R7 row%0d ack", k), ack, VECS[k].ack);
      if (VECS[k].rd_en) begin
        read_byte(VECS[k].comp_en, {VECS[k].comp, 1'b0}, rd);
        chk($sformatf("R4 R5 row%0d reply byte", k), rd, VECS[k].rd);
      end
      bus_stop();
      chk($sformatf("R5 R6 row%0d alert after", k), alert_pull, VECS[k].alert);
      chk($sformatf("R10 row%0d released after stop", k), sda_pull, 0);
    end

    // R3: after a mismatch, own address bits without a new START are ignored
    own = 7'h12;
    bus_start();
    write_byte(8'h26, 0, 1'b0, ack);
    chk("R3 mismatch nack", ack, 0);
    write_byte(8'h24, 0, 1'b0, ack);
    chk("R3 ignored until START", ack, 0);
    bus_stop();

    // R10: repeated START in mid-byte restarts address reception
    bus_start();
    for (int i = 0; i < 4; i++) clk_bit(1'b1, 0, r);
    bus_start();
    write_byte(8'h24, 0, 1'b0, ack);
    chk("R10 repeated START ack", ack, 1);
    bus_stop();

    // R10: STOP after ack returns to idle; later bits without START ignored
    bus_start();
    write_byte(8'h25, 0, 1'b0, ack);
    chk("R2 read-direction ack", ack, 1);
    bus_stop();
    host_scl = 1'b0; wait_clk(HALF);
    write_byte(8'h24, 0, 1'b0, ack);
    chk("R10 idle after STOP", ack, 0);
    host_sda = 1'b1; wait_clk(HALF);
    host_scl = 1'b1; wait_clk(HALF);

    // R8: stretched low periods below the limit
    bus_start();
    write_byte(8'h24, 150, 1'b0, ack);
    chk("R8 ack with stretched clock", ack, 1);
    bus_stop();
    chk("R8 no timeout while stretched", to_cnt, 0);

    // R9: clock held low while the target drives a reply 0
    pulse_alert();
    bus_start();
    write_byte(8'h19, 0, 1'b0, ack);
    chk("R4 alert read ack", ack, 1);
    for (int i = 0; i < 3; i++) clk_bit(1'b1, 0, r);
    wait_clk(8);
    chk("R4 driving reply bit4=0", sda_pull, 1);
    wait_clk(LIM + 50);
    chk("R9 one timeout pulse", to_cnt, 1);
    chk("R9 data released", sda_pull, 0);
    chk("R9 alert kept", alert_pull, 1);
    host_sda = 1'b1; wait_clk(HALF);
    host_scl = 1'b1; wait_clk(HALF);
    bus_start();
    write_byte(8'h19, 0, 1'b0, ack);
    chk("R9 ack after timeout recovery", ack, 1);
    read_byte(1'b0, 8'h00, rd);
    chk("R4 reply after recovery", rd, 8'h24);
    bus_stop();
    chk("R6 alert cleared after win", alert_pull, 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule